// File: doc/BRIEF.md
# Over-Temperature Alarm Controller

This block decides when a hot-temperature alarm should be raised. Each finished temperature measurement arrives as a one-cycle strobe with an 8-bit signed reading. The block compares that reading against two programmable thresholds: an upper trip point and a lower release point, which is set a few degrees under the trip point. From these comparisons it drives an active-low alarm pin and keeps a one-bit status flag.

Software picks one of three alarm policies. The first is a plain thermostat that follows the trip point and ignores the release point. The second is a latched policy that fires again after every measurement until the temperature falls under the release point. The third is a latched policy that fires once per excursion. Reading the status flag returns it and then clears it.

A separate clear control silences the pin without touching the status flag. While that control is high, the block also stops the measurement loop: it lowers its monitor-enable output and discards any measurement that arrives.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: With mode field 2'b10 (thermostat), a measurement strictly above the trip point drives `alarm_n` low, and one strictly below the trip point drives it high. A measurement equal to the trip point leaves the pin unchanged. The release point has no effect, and a status read does not raise the pin.
- R2: With mode field 2'b00 (repeating), a measurement strictly above the trip point sets the status flag and latches `alarm_n` low. The pin stays low until a status read or the clear control.
- R3: In repeating mode, an excursion starts when a measurement is above the trip point. Until a measurement falls strictly below the release point, every accepted measurement fires the alarm again, even one that is not above the trip point. Once a measurement has fallen below the release point, readings between the two thresholds do not fire.
- R4: With mode field 2'b01 (single-shot), a measurement above the trip point fires only when the block is not locked out. Firing locks it out. The lockout ends only when a measurement falls strictly below the release point. Reset ends any lockout.
- R5: A cycle with `stat_rd` high clears the status flag and the latched alarm at the next clock edge. If an accepted measurement fires in the same cycle, the flag and the alarm end up set.
- R6: While `clr_req` is high, `alarm_n` is high in every mode, and the status flag keeps its value unless it is read.
- R7: `mon_en` is the inverse of `clr_req`. A measurement strobe that arrives while `clr_req` is high changes no state.
- R8: All three values are compared as two's-complement numbers.
- R9: Mode field 2'b11 behaves exactly like repeating mode.
- R10: After a synchronous reset, `alarm_n` is high and `stat_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_vld | input | 1 | One-cycle strobe: a measurement is complete |
| meas_temp | input | 8 | Signed measured temperature |
| trip_lim | input | 8 | Signed trip point |
| rel_lim | input | 8 | Signed release point |
| mode_sel | input | 2 | Alarm policy (00 repeating, 01 single-shot, 10 thermostat, 11 repeating) |
| stat_rd | input | 1 | Status read strobe; clears the flag after it is returned |
| clr_req | input | 1 | Clear control: silences the pin and halts monitoring |
| alarm_n | output | 1 | Alarm pin, active low |
| stat_flag | output | 1 | Status flag as seen by a read |
| mon_en | output | 1 | High while the measurement loop may run |

## Verification
A status read and a measurement that fires can land on the same clock edge. The bench provokes this by raising `stat_rd` in the same cycle as a strobe that is still inside the hot excursion. The expected result is that the new event wins: the flag stays set and the pin stays low.

The bench also collides the clear control with a measurement strobe. The expected result there is that the strobe is dropped. This is judged by the flag and the pin after `clr_req` falls.

// File: rtl/tac_pkg.sv
package tac_pkg;

    localparam int TEMP_W = 8;

    typedef enum logic [1:0] {
        MODE_REPEAT  = 2'b00,
        MODE_ONCE    = 2'b01,
        MODE_THERMO  = 2'b10,
        MODE_SPARE   = 2'b11
    } mode_t;

    // comparison results for one measurement
    typedef struct packed {
        logic above_trip;
        logic below_trip;
        logic below_rel;
    } cmp_t;

    // excursion tracking flags
    typedef struct packed {
        logic in_zone;   // above trip seen, not yet below release
        logic locked;    // single-shot lockout
        logic thermo;    // thermostat state
    } track_t;

    // the spare encoding folds onto the repeating policy
    function automatic mode_t fold_mode(logic [1:0] raw);
        mode_t m;
        if (raw == 2'b11) m = MODE_REPEAT;
        else              m = mode_t'(raw);
        return m;
    endfunction

endpackage

// File: rtl/tac_compare.sv
module tac_compare
    import tac_pkg::*;
#(
    parameter int W = TEMP_W
) (
    input  logic [W-1:0] temp,
    input  logic [W-1:0] trip,
    input  logic [W-1:0] rel,
    output cmp_t         res
);

    always_comb begin
        res.above_trip = $signed(temp) > $signed(trip);
        res.below_trip = $signed(temp) < $signed(trip);
        res.below_rel  = $signed(temp) < $signed(rel);
    end

endmodule

// File: rtl/tac_tracker.sv
module tac_tracker
    import tac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  mode_t mode,
    input  cmp_t  cmp,
    output logic  latch_set,
    output logic  stat_set,
    output logic  thermo_q
);

    track_t st_q, st_d;
    logic   fire;

    always_comb begin
        unique case (mode)
            MODE_ONCE:   fire = cmp.above_trip & ~st_q.locked;
            MODE_THERMO: fire = 1'b0;
            default:     fire = cmp.above_trip | (st_q.in_zone & ~cmp.below_rel);
        endcase
    end

    assign latch_set = accept & fire;
    assign stat_set  = accept & ((mode == MODE_THERMO) ? cmp.above_trip : fire);
    assign thermo_q  = st_q.thermo;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            if (cmp.above_trip)     st_d.in_zone = 1'b1;
            else if (cmp.below_rel) st_d.in_zone = 1'b0;

            if (cmp.above_trip)      st_d.thermo = 1'b1;
            else if (cmp.below_trip) st_d.thermo = 1'b0;

            if (cmp.below_rel)                    st_d.locked = 1'b0;
            else if (mode == MODE_ONCE && fire)   st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/tac_status.sv
module tac_status (
    input  logic clk,
    input  logic rst,
    input  logic stat_set,
    input  logic latch_set,
    input  logic rd,
    input  logic clr,
    output logic stat_q,
    output logic latch_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            // a new event outranks the read-clear in the same cycle
            if (stat_set)  stat_q <= 1'b1;
            else if (rd)   stat_q <= 1'b0;

            if (latch_set)       latch_q <= 1'b1;
            else if (rd || clr)  latch_q <= 1'b0;
        end
    end

endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl
    import tac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_vld,
    input  logic [TEMP_W-1:0] meas_temp,
    input  logic [TEMP_W-1:0] trip_lim,
    input  logic [TEMP_W-1:0] rel_lim,
    input  logic [1:0]        mode_sel,
    input  logic              stat_rd,
    input  logic              clr_req,
    output logic              alarm_n,
    output logic              stat_flag,
    output logic              mon_en
);

    mode_t mode;
    cmp_t  cmp;
    logic  accept;
    logic  latch_set, stat_set, thermo_q;
    logic  stat_q, latch_q;
    logic  alarm_act;

    assign mode   = fold_mode(mode_sel);
    assign mon_en = ~clr_req;
    assign accept = meas_vld & ~clr_req;

    tac_compare #(.W(TEMP_W)) u_cmp (
        .temp (meas_temp),
        .trip (trip_lim),
        .rel  (rel_lim),
        .res  (cmp)
    );

    tac_tracker u_trk (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .mode      (mode),
        .cmp       (cmp),
        .latch_set (latch_set),
        .stat_set  (stat_set),
        .thermo_q  (thermo_q)
    );

    tac_status u_st (
        .clk       (clk),
        .rst       (rst),
        .stat_set  (stat_set),
        .latch_set (latch_set),
        .rd        (stat_rd),
        .clr       (clr_req),
        .stat_q    (stat_q),
        .latch_q   (latch_q)
    );

    assign alarm_act = ((mode == MODE_THERMO) ? thermo_q : latch_q) & ~clr_req;
    assign alarm_n   = ~alarm_act;
    assign stat_flag = stat_q;

endmodule

// File: rtl/tac_checker.sv
module tac_checker (
    input logic       clk,
    input logic       rst,
    input logic       meas_vld,
    input logic [7:0] meas_temp,
    input logic [7:0] trip_lim,
    input logic [1:0] mode_sel,
    input logic       stat_rd,
    input logic       clr_req,
    input logic       alarm_n,
    input logic       stat_flag,
    input logic       mon_en
);

    a_r6_clear_silences: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> alarm_n);

    a_r7_mon_halt: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> !mon_en);

    a_r7_strobe_dropped: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !stat_rd) |=> (stat_flag == $past(stat_flag)));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !meas_vld) |=> !stat_flag);

    a_r1_thermo_trip: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10 && meas_vld && !clr_req &&
         $signed(meas_temp) > $signed(trip_lim)) |=> (clr_req || !alarm_n));

    a_r2_flag_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_flag) |-> $past(meas_vld && !clr_req));

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (alarm_n && !stat_flag));

endmodule

bind temp_alarm_ctrl tac_checker u_tac_chk (
    .clk       (clk),
    .rst       (rst),
    .meas_vld  (meas_vld),
    .meas_temp (meas_temp),
    .trip_lim  (trip_lim),
    .mode_sel  (mode_sel),
    .stat_rd   (stat_rd),
    .clr_req   (clr_req),
    .alarm_n   (alarm_n),
    .stat_flag (stat_flag),
    .mon_en    (mon_en)
);

// File: tb/temp_alarm_ctrl_bench.sv
module temp_alarm_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    logic       clk = 1'b0;
    logic       rst;
    logic       meas_vld;
    logic [7:0] meas_temp, trip_lim, rel_lim;
    logic [1:0] mode_sel;
    logic       stat_rd, clr_req;
    logic       alarm_n, stat_flag, mon_en;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_alarm_ctrl u_temp_alarm_ctrl (
        .clk       (clk),
        .rst       (rst),
        .meas_vld  (meas_vld),
        .meas_temp (meas_temp),
        .trip_lim  (trip_lim),
        .rel_lim   (rel_lim),
        .mode_sel  (mode_sel),
        .stat_rd   (stat_rd),
        .clr_req   (clr_req),
        .alarm_n   (alarm_n),
        .stat_flag (stat_flag),
        .mon_en    (mon_en)
    );

    // {mode, vld, temp, rd, clr, exp_alarm_n, exp_flag}; trip 50, release 40
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 8'd30, 1'b0, 1'b0, 1'b1, 1'b0},  //  0 R2 cool
        {2'd0, 1'b1, 8'd60, 1'b0, 1'b0, 1'b0, 1'b1},  //  1 R2 fire
        {2'd0, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  //  2 R5 read
        {2'd0, 1'b1, 8'd45, 1'b0, 1'b0, 1'b0, 1'b1},  //  3 R3 repeat
        {2'd0, 1'b1, 8'd45, 1'b1, 1'b0, 1'b0, 1'b1},  //  4 R5 read+fire
        {2'd0, 1'b1, 8'd45, 1'b0, 1'b1, 1'b1, 1'b1},  //  5 R6 clear
        {2'd0, 1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b1},  //  6 R6 after clear
        {2'd0, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  //  7 R5 read
        {2'd0, 1'b1, 8'd35, 1'b0, 1'b0, 1'b1, 1'b0},  //  8 R3 leave zone
        {2'd0, 1'b1, 8'd45, 1'b0, 1'b0, 1'b1, 1'b0},  //  9 R3 no fire
        {2'd1, 1'b1, 8'd60, 1'b0, 1'b0, 1'b0, 1'b1},  // 10 R4 fire
        {2'd1, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  // 11 R5 read
        {2'd1, 1'b1, 8'd60, 1'b0, 1'b0, 1'b1, 1'b0},  // 12 R4 locked
        {2'd1, 1'b1, 8'd35, 1'b0, 1'b0, 1'b1, 1'b0},  // 13 R4 unlock
        {2'd1, 1'b1, 8'd55, 1'b0, 1'b0, 1'b0, 1'b1},  // 14 R4 refire
        {2'd1, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  // 15 R5 read
        {2'd2, 1'b1, 8'd55, 1'b0, 1'b0, 1'b0, 1'b1},  // 16 R1 trip
        {2'd2, 1'b1, 8'd50, 1'b0, 1'b0, 1'b0, 1'b1},  // 17 R1 equal holds
        {2'd2, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0},  // 18 R1 read keeps pin
        {2'd2, 1'b1, 8'd45, 1'b0, 1'b0, 1'b1, 1'b0},  // 19 R1 release ignored
        {2'd3, 1'b1, 8'd60, 1'b0, 1'b0, 1'b0, 1'b1},  // 20 R9 fire
        {2'd3, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 1'b0},  // 21 R9 read
        {2'd3, 1'b1, 8'd42, 1'b0, 1'b0, 1'b0, 1'b1}   // 22 R9 repeats
    };
    localparam int VREQ [NVEC] = '{2,2,5,3,5,6,6,5,3,3,4,5,4,4,4,5,1,1,1,1,9,9,9};

    task automatic chk(input logic got, input logic exp, input int req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic v, input logic [7:0] t,
                        input logic rd, input logic cl);
        @(negedge clk);
        mode_sel = m; meas_vld = v; meas_temp = t; stat_rd = rd; clr_req = cl;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; meas_vld = 1'b0; stat_rd = 1'b0; clr_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; meas_vld = 1'b0; meas_temp = '0; mode_sel = 2'd0;
        stat_rd = 1'b0; clr_req = 1'b0; trip_lim = 8'd50; rel_lim = 8'd40;
        do_reset();
        #1;
        chk(alarm_n, 1'b1, 10, "reset alarm_n");   // R10
        chk(stat_flag, 1'b0, 10, "reset flag");    // R10
        chk(mon_en, 1'b1, 7, "reset mon_en");      // R7

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][14:13], VEC[i][12], VEC[i][11:4], VEC[i][3], VEC[i][2]);
            chk(alarm_n, VEC[i][1], VREQ[i], $sformatf("row %0d alarm_n", i));
            chk(stat_flag, VEC[i][0], VREQ[i], $sformatf("row %0d flag", i));
            chk(mon_en, ~VEC[i][2], 7, $sformatf("row %0d mon_en", i)); // R7
        end

        // R10: reset from an alarmed state
        step(2'd0, 1'b1, 8'd70, 1'b0, 1'b0);
        do_reset();
        #1;
        chk(alarm_n, 1'b1, 10, "reset after alarm pin");
        chk(stat_flag, 1'b0, 10, "reset after alarm flag");

        // R7: hot strobe during clear is dropped
        step(2'd0, 1'b1, 8'd70, 1'b0, 1'b1);
        chk(mon_en, 1'b0, 7, "mon_en during clear");
        step(2'd0, 1'b0, 8'd0, 1'b0, 1'b0);
        chk(stat_flag, 1'b0, 7, "flag after dropped strobe");
        chk(alarm_n, 1'b1, 7, "pin after dropped strobe");
        step(2'd0, 1'b1, 8'd45, 1'b0, 1'b0);
        chk(alarm_n, 1'b1, 7, "no zone from dropped strobe");

        // R8: signed thresholds, trip -10, release -20
        do_reset();
        trip_lim = 8'hF6; rel_lim = 8'hEC;
        step(2'd2, 1'b1, 8'd5, 1'b0, 1'b0);
        chk(alarm_n, 1'b0, 8, "positive above negative trip");
        step(2'd2, 1'b1, 8'h90, 1'b0, 1'b0);
        chk(alarm_n, 1'b1, 8, "-112 below negative trip");
        step(2'd1, 1'b1, 8'hF0, 1'b0, 1'b0);
        chk(alarm_n, 1'b1, 8, "-16 not above -10");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule